// File: doc/BRIEF.md
# Tiny Multicycle Word Processor Core

This block is a small multicycle processor core that runs programs out of one internal 128-word memory of 16-bit words. Code and data live in that same memory, so a program can read its own constants and even its own instruction words as data. The core has eight 16-bit general registers. Register 0 is wired to zero, so it serves as a zero base for absolute loads, and "branch if r0 equals r0" acts as an unconditional jump.

A host fills the memory through a simple load port (address, data, write enable) while the core is idle. It then pulses `start`. The core begins at address 0 and steps each instruction through fetch, decode and execute. Loads add a memory-read state, and adds and loads add a register writeback state. Four operations are implemented: register add, load word, branch-if-equal with a signed 7-bit offset relative to the next PC, and halt. Execution continues until a halt instruction raises `halted`. The program counter and a debug read of any register are visible at the ports.

Top module: `mini_core`

## Requirements
- R1: After reset, `halted` is 0, `pc` is 0 and every register reads 0 on the debug port. Without a start pulse the core stays idle and `pc` does not move.
- R2: Instruction bits [15:13] hold the opcode. Opcode 000 is add: the register named by bits [12:10] receives the sum, modulo 2^16, of the registers named by bits [9:7] and bits [2:0]. Bits [6:3] are zero.
- R3: Opcode 100 is load. The register named by bits [12:10] receives the memory word at address (register[bits 9:7] + bits [6:0]) modulo 128, with the 7-bit field taken as unsigned.
- R4: Opcode 110 is branch-if-equal. When the registers named by bits [12:10] and [9:7] are equal, the PC becomes (PC + 1 + offset) modulo 128, with bits [6:0] read as two's complement. Otherwise the PC becomes PC + 1.
- R5: Opcode 011 is halt. It raises `halted`, and `pc` then holds the address of the halt instruction. Neither changes until the next start pulse.
- R6: Register 0 always reads as zero. Writes to it by add or load have no effect.
- R7: The remaining opcodes (001, 010, 101, 111) change no register and advance the PC by 1. PC increments wrap from 127 to 0.
- R8: A start pulse sampled while the core is idle or halted sets the PC to 0 and begins fetching. Counted in rising edges from the one that samples start, a lone halt raises `halted` after 4 edges. Each branch or unused opcode takes 3 edges, each add 4 and each load 5.
- R9: A load-port write stores `ld_data` at `ld_addr` on the rising edge where `ld_we` is high. Loads can read instruction words, because code and data share one address space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin execution at address 0 |
| ld_we | input | 1 | Memory load-port write enable |
| ld_addr | input | 7 | Memory load-port address |
| ld_data | input | 16 | Memory load-port write data |
| dbg_sel | input | 3 | Register index for the debug read |
| dbg_data | output | 16 | Contents of the selected register |
| halted | output | 1 | High once a halt instruction has executed |
| pc | output | 7 | Current program counter |

## Verification
The assertions assume that the load port is used only while the core is idle or halted, and that `start` is a single-cycle pulse given only in those states. The bench drives `ld_we` and `start` solely between runs, and holds both low while a program executes. The assertions also rely on the memory being fully written before a run. The bench therefore writes all 128 words for every program, including the zero words, so no fetch or load ever reads an unknown value. Randomized programs draw data values and register indices from a fixed seed, but they keep the fixed field layout: bits [6:3] of every add are zero and every load address lands inside the data area.

// File: rtl/mini_core.sv
module mini_core #(
  parameter int DW = 16,
  parameter int AW = 7,
  parameter int RW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          ld_we,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  input  logic [RW-1:0] dbg_sel,
  output logic [DW-1:0] dbg_data,
  output logic          halted,
  output logic [AW-1:0] pc
);
  localparam int DEPTH = 1 << AW;
  localparam int NREG  = 1 << RW;
  localparam logic [2:0] OP_ADD = 3'b000, OP_HALT = 3'b011, OP_LW = 3'b100, OP_BEQ = 3'b110;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_DECODE, S_EXEC, S_MEM, S_WB, S_HALT} st_t;

  st_t           st;
  logic [AW-1:0] pc_q, maddr;
  logic [DW-1:0] ir, opa, opb, res;
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rf  [NREG];

  wire [2:0]    op  = ir[15:13];
  wire [RW-1:0] fa  = ir[12:10];
  wire [RW-1:0] fb  = ir[9:7];
  wire [RW-1:0] fc  = ir[2:0];
  wire [6:0]    imm = ir[6:0];

  wire [AW-1:0] pc_next = pc_q + AW'(1);
  wire [AW-1:0] br_tgt  = pc_q + AW'(1) + AW'($signed(imm));

  function automatic logic [DW-1:0] rd(input logic [RW-1:0] idx);
    return (idx == '0) ? '0 : rf[idx];
  endfunction

  assign dbg_data = rd(dbg_sel);
  assign halted   = (st == S_HALT);
  assign pc       = pc_q;

  always_ff @(posedge clk) begin
    if (ld_we) mem[ld_addr] <= ld_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      pc_q  <= '0;
      ir    <= '0;
      opa   <= '0;
      opb   <= '0;
      res   <= '0;
      maddr <= '0;
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else begin
      case (st)
        S_IDLE, S_HALT: if (start) begin
          pc_q <= '0;
          st   <= S_FETCH;
        end
        S_FETCH: begin
          ir <= mem[pc_q];
          st <= S_DECODE;
        end
        S_DECODE: begin
          opa <= rd((op == OP_ADD) ? fb : fa);
          opb <= rd((op == OP_ADD) ? fc : fb);
          st  <= S_EXEC;
        end
        S_EXEC: begin
          case (op)
            OP_ADD: begin
              res <= opa + opb;
              st  <= S_WB;
            end
            OP_LW: begin
              maddr <= opb[AW-1:0] + AW'(imm);
              st    <= S_MEM;
            end
            OP_BEQ: begin
              pc_q <= (opa == opb) ? br_tgt : pc_next;
              st   <= S_FETCH;
            end
            OP_HALT: st <= S_HALT;
            default: begin
              pc_q <= pc_next;
              st   <= S_FETCH;
            end
          endcase
        end
        S_MEM: begin
          res <= mem[maddr];
          st  <= S_WB;
        end
        S_WB: begin
          if (fa != '0) rf[fa] <= res;
          pc_q <= pc_next;
          st   <= S_FETCH;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R8
  start_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_IDLE || st == S_HALT) && start) |=> (st == S_FETCH && pc_q == '0));

  // R5
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !start) |=> (halted && $stable(pc_q)));

  // R8
  load_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_MEM) |=> (st == S_WB));

  // R7
  nop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_EXEC && (op == 3'b001 || op == 3'b010 || op == 3'b101 || op == 3'b111))
    |=> (st == S_FETCH && pc_q == AW'($past(pc_q) + AW'(1))));

  // R4
  beq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_EXEC && op == OP_BEQ && opa != opb)
    |=> (st == S_FETCH && pc_q == AW'($past(pc_q) + AW'(1))));

  // R6
  r0_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_sel == '0) |-> (dbg_data == '0));
endmodule

// File: tb/mini_core_tb.sv
`timescale 1ns/1ps
module mini_core_tb_top;
  logic        clk = 0, rst_n = 0, start = 0, ld_we = 0;
  logic [6:0]  ld_addr = 0;
  logic [15:0] ld_data = 0;
  logic [2:0]  dbg_sel = 0;
  logic [15:0] dbg_data;
  logic        halted;
  logic [6:0]  pc;
  int checks = 0, failures = 0;
  logic [15:0] img [128];

  always #2 clk = ~clk;

  mini_core dut_i (.clk(clk), .rst_n(rst_n), .start(start), .ld_we(ld_we), .ld_addr(ld_addr),
    .ld_data(ld_data), .dbg_sel(dbg_sel), .dbg_data(dbg_data), .halted(halted), .pc(pc));

  function automatic logic [15:0] enc(input logic [2:0] op, input logic [2:0] a,
                                      input logic [2:0] b, input logic [6:0] imm);
    return {op, a, b, imm};
  endfunction
  function automatic logic [15:0] eadd(input logic [2:0] d, input logic [2:0] s1, input logic [2:0] s2);
    return {3'b000, d, s1, 4'b0000, s2};
  endfunction
  function automatic logic [15:0] ehalt();
    return 16'h6000;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_reg(input int r, input logic [15:0] exp, input string req);
    @(negedge clk); dbg_sel = r[2:0]; #1;
    chk(dbg_data === exp, req, dbg_data, exp);
  endtask

  task automatic clear_img();
    for (int i = 0; i < 128; i++) img[i] = 16'h0000;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic load_img();
    for (int i = 0; i < 128; i++) begin
      @(negedge clk); ld_we = 1; ld_addr = i[6:0]; ld_data = img[i];
    end
    @(negedge clk); ld_we = 0;
  endtask

  task automatic run_prog(output int cyc);
    load_img();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    cyc = 1;
    while (!halted && cyc < 4000) begin
      @(negedge clk); cyc++;
    end
    if (!halted) chk(0, "R5 run did not halt", cyc, 4000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog R5 actual=timeout expected=halt");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int cyc, stop_i;
    logic [15:0] stop_v;
    logic [15:0] m [8];
    void'($urandom(32'h5EED_1234));
    do_reset();

    // R1 reset state and idle without start
    chk(halted === 0, "R1 halted after reset", halted, 0);
    chk(pc === 0, "R1 pc after reset", pc, 0);
    for (int r = 0; r < 8; r++) chk_reg(r, 16'h0, "R1 reg after reset");
    repeat (10) @(negedge clk);
    chk(pc === 0 && halted === 0, "R1 idle without start", pc, 0);

    // R8 R5 lone halt timing and hold
    clear_img(); img[0] = ehalt();
    run_prog(cyc);
    chk(cyc == 4, "R8 halt latency", cyc, 4);
    chk(pc === 0, "R5 pc holds halt address", pc, 0);
    repeat (6) @(negedge clk);
    chk(halted === 1 && pc === 0, "R5 halted hold", pc, 0);
    // R8 restart from halted
    run_prog(cyc);
    chk(cyc == 4, "R8 restart from halted", cyc, 4);

    // R8 add, load, branch latencies
    do_reset(); clear_img(); img[0] = eadd(1, 0, 0); img[1] = ehalt();
    run_prog(cyc); chk(cyc == 8, "R8 add latency", cyc, 8);
    do_reset(); clear_img(); img[0] = enc(3'b100, 1, 0, 7'd9); img[1] = ehalt(); img[9] = 16'h1234;
    run_prog(cyc); chk(cyc == 9, "R8 load latency", cyc, 9);
    chk_reg(1, 16'h1234, "R3 absolute load");
    do_reset(); clear_img(); img[0] = enc(3'b110, 0, 0, 7'd0); img[1] = ehalt();
    run_prog(cyc); chk(cyc == 7, "R8 branch latency", cyc, 7);

    // R2 R3 R4 search loop with random stop position
    for (int t = 0; t < 3; t++) begin
      do_reset(); clear_img();
      stop_i = $urandom_range(0, 9);
      stop_v = 16'($urandom_range(1, 16'hFFFF));
      img[0] = enc(3'b100, 1, 0, 7'd9);
      img[1] = enc(3'b100, 2, 0, 7'd10);
      img[2] = enc(3'b100, 3, 0, 7'd11);
      img[3] = enc(3'b100, 4, 1, 7'd12);
      img[4] = enc(3'b110, 4, 3, 7'd1);
      img[5] = enc(3'b110, 0, 0, 7'd2);
      img[6] = eadd(1, 1, 2);
      img[7] = enc(3'b110, 0, 0, 7'b1111011);
      img[8] = ehalt();
      img[10] = 16'd1;
      img[12 + stop_i] = stop_v;
      run_prog(cyc);
      chk(pc === 8, "R4 loop exit pc", pc, 8);
      chk_reg(1, 16'(stop_i), "R2 loop index");
      chk_reg(2, 16'd1, "R3 loop step");
      chk_reg(4, stop_v, "R3 indexed load");
    end

    // R4 R7 negative/large offset, unused opcodes, pc wrap
    do_reset(); clear_img();
    img[0]   = enc(3'b110, 5, 0, 7'd3);
    img[1]   = ehalt();
    img[4]   = enc(3'b100, 5, 0, 7'd20);
    img[5]   = enc(3'b110, 0, 0, 7'd120);
    img[126] = 16'hFFFF;
    img[127] = 16'hA000;
    img[20]  = 16'd9;
    img[2]   = 16'h2000;
    run_prog(cyc);
    chk(pc === 1, "R7 wrap to 0 then halt", pc, 1);
    chk_reg(5, 16'd9, "R4 taken then not taken");
    for (int r = 1; r < 8; r++) if (r != 5) chk_reg(r, 16'h0, "R7 unused opcode no effect");

    // R6 writes to r0 ignored
    do_reset(); clear_img();
    img[0] = enc(3'b100, 0, 0, 7'd20);
    img[1] = enc(3'b100, 6, 0, 7'd21);
    img[2] = eadd(0, 6, 6);
    img[3] = enc(3'b100, 7, 0, 7'd21);
    img[4] = eadd(7, 0, 7);
    img[5] = ehalt();
    img[20] = 16'd55; img[21] = 16'd300;
    run_prog(cyc);
    chk_reg(0, 16'h0, "R6 r0 stays zero");
    chk_reg(7, 16'd300, "R6 r0 base still zero");

    // R9 load of own instruction word
    do_reset(); clear_img();
    img[0] = enc(3'b100, 3, 0, 7'd0);
    img[1] = ehalt();
    run_prog(cyc);
    chk_reg(3, img[0], "R9 load own code word");

    // R2 random add chains
    for (int t = 0; t < 4; t++) begin
      logic [2:0] d, s1, s2;
      do_reset(); clear_img();
      m[0] = 16'h0;
      for (int k = 1; k < 8; k++) begin
        m[k] = 16'($urandom());
        img[40 + k] = m[k];
        img[k - 1] = enc(3'b100, k[2:0], 0, 7'(40 + k));
      end
      for (int a = 0; a < 6; a++) begin
        d = 3'($urandom_range(0, 7)); s1 = 3'($urandom_range(0, 7)); s2 = 3'($urandom_range(0, 7));
        img[7 + a] = eadd(d, s1, s2);
        if (d != 0) m[d] = m[s1] + m[s2];
      end
      img[13] = ehalt();
      run_prog(cyc);
      for (int r = 0; r < 8; r++) chk_reg(r, m[r], "R2 random add chain");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule